// File: doc/BRIEF.md
# Pipeline Stage Controller with Cancel

This block controls one stage of a valid/ready pipeline. A transaction offered by the upstream side is held in the stage's node. Logic inside the stage can issue a local halt, which stalls the transaction, or a local throw, which drops it so that it never reaches the next stage. A register link carries the surviving transactions to the downstream side. The downstream side answers with ready and with a cancel that removes the transaction held in that register.

The controller decodes four status outputs for logic inside the stage: valid, firing, moving and canceling. Stage logic commits side effects on firing and resets per-transaction state on moving. A mode input selects how a throw treats upstream. In consuming mode a throw takes the transaction from upstream at once, which is the way a branch flushes younger stages. In the other mode the dropped transaction leaves upstream only when the register link could have accepted it. The payload width is a parameter.

Top module: `stage_ctrl`

## Requirements
- R1: After `rst_n` is released, `dn_valid` is 0. `dn_valid` and `dn_data` come straight from the register and do not depend combinationally on `dn_ready` or `dn_cancel`.
- R2: The link accepts (link-ready) when its register is empty, when `dn_ready` is 1, or when `dn_cancel` is 1. With no halt and no throw, `up_ready` equals link-ready.
- R3: While `stage_halt` is 1 and `stage_throw` is 0, the stage does not fire. Node ready is 0. `up_ready` is 0. The register loads a bubble if it is link-ready.
- R4: A transaction on which `stage_throw` is 1 when it moves is never presented on `dn_valid`. When halt and throw are both 1, throw wins.
- R5: The node cancel is `stage_throw AND (throw_consume OR link-ready)`. `up_ready` = node-ready OR node-cancel. So with `throw_consume`=1 a throw makes `up_ready` 1 whatever the downstream state is. With `throw_consume`=0 and the link not ready, a throw stalls.
- R6: `st_valid` = `up_valid`. `st_firing` = valid AND node-ready AND NOT node-cancel. A firing transaction appears on `dn_valid` at the next clock edge with `dn_data` equal to its `up_data`.
- R7: `st_moving` = valid AND (node-ready OR node-cancel). This is 1 exactly when upstream hands the transaction over, that is `up_valid` AND `up_ready`.
- R8: `st_canceling` = valid AND node-cancel. Firing and canceling are never 1 together.
- R9: When `dn_valid` and `dn_cancel` are both 1, the held transaction leaves the register and is never presented again.
- R10: Transactions reach `dn_data` in the order they fired. None is lost or duplicated: fired = delivered + cancelled downstream + still held.
- R11: While `dn_valid`=1, `dn_ready`=0 and `dn_cancel`=0, the next cycle keeps `dn_valid`=1 with `dn_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream transaction present |
| up_ready | output | 1 | Upstream transaction taken this cycle |
| up_data | input | DATA_W | Upstream payload |
| stage_halt | input | 1 | Local stall request |
| stage_throw | input | 1 | Local drop request |
| throw_consume | input | 1 | 1: a throw consumes upstream at once |
| st_valid | output | 1 | Stage holds a transaction |
| st_firing | output | 1 | Transaction advances to the register |
| st_moving | output | 1 | Transaction leaves the node this cycle |
| st_canceling | output | 1 | Transaction is being dropped |
| dn_valid | output | 1 | Register holds a transaction |
| dn_ready | input | 1 | Downstream takes the held transaction |
| dn_cancel | input | 1 | Downstream removes the held transaction |
| dn_data | output | DATA_W | Registered payload |

## Verification
The bench builds the block with `DATA_W`=16. Each offered transaction carries a unique sequence number, so any loss, duplicate, reordering or leaked thrown item shows up as a wrong number at `dn_data`. Directed phases come first: a full register with downstream stalled, halt together with throw, and throw in both consume modes. Long random runs follow with each mode held fixed. Together they reach the case where a non-consuming throw meets a full register, and the case where a downstream cancel and a new fire happen in the same cycle.

// File: rtl/stage_ctrl_pkg.sv
package stage_ctrl_pkg;

  typedef struct packed {
    logic valid;
    logic firing;
    logic moving;
    logic canceling;
  } node_status_t;

endpackage

// File: rtl/stage_node_arb.sv
module stage_node_arb
  import stage_ctrl_pkg::*;
(
  input  logic         in_valid,
  input  logic         link_ready,
  input  logic         halt_req,
  input  logic         throw_req,
  input  logic         throw_consume,
  output logic         up_ready,
  output logic         load_valid,
  output node_status_t status
);

  logic node_ready;
  logic node_cancel;

  // A throw removes the transaction when it may consume upstream,
  // either unconditionally or only when the link could accept.
  always_comb begin
    node_cancel      = throw_req & (throw_consume | link_ready);
    node_ready       = link_ready & ~halt_req;
    up_ready         = node_ready | node_cancel;
    status.valid     = in_valid;
    status.firing    = in_valid & node_ready & ~node_cancel;
    status.moving    = in_valid & (node_ready | node_cancel);
    status.canceling = in_valid & node_cancel;
    load_valid       = status.firing;
  end

endmodule

// File: rtl/stage_reg_link.sv
module stage_reg_link #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  input  logic              dn_ready,
  input  logic              dn_cancel,
  output logic              link_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q;
  logic              dat_en;

  always_comb begin
    link_ready = ~vld_q | dn_ready | dn_cancel;
    vld_d      = vld_q;
    if (link_ready) vld_d = load_valid;
    dat_en     = link_ready & load_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= load_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import stage_ctrl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              stage_halt,
  input  logic              stage_throw,
  input  logic              throw_consume,
  output logic              st_valid,
  output logic              st_firing,
  output logic              st_moving,
  output logic              st_canceling,
  output logic              dn_valid,
  input  logic              dn_ready,
  input  logic              dn_cancel,
  output logic [DATA_W-1:0] dn_data
);

  logic         link_ready;
  logic         load_valid;
  node_status_t status;

  stage_node_arb u_arb (
    .in_valid      (up_valid),
    .link_ready    (link_ready),
    .halt_req      (stage_halt),
    .throw_req     (stage_throw),
    .throw_consume (throw_consume),
    .up_ready      (up_ready),
    .load_valid    (load_valid),
    .status        (status)
  );

  stage_reg_link #(.DATA_W(DATA_W)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_data  (up_data),
    .dn_ready   (dn_ready),
    .dn_cancel  (dn_cancel),
    .link_ready (link_ready),
    .out_valid  (dn_valid),
    .out_data   (dn_data)
  );

  assign st_valid     = status.valid;
  assign st_firing    = status.firing;
  assign st_moving    = status.moving;
  assign st_canceling = status.canceling;

endmodule

// File: rtl/stage_ctrl_checker.sv
module stage_ctrl_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic              stage_halt,
  input logic              stage_throw,
  input logic              throw_consume,
  input logic              st_valid,
  input logic              st_firing,
  input logic              st_moving,
  input logic              st_canceling,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_cancel,
  input logic [DATA_W-1:0] dn_data
);

  assert_empty_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && !stage_halt) |-> up_ready);

  assert_halt_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_halt && !stage_throw) |-> (!up_ready && !st_firing));

  assert_throw_no_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stage_throw |-> !st_firing);

  assert_consume_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_throw && throw_consume) |-> up_ready);

  assert_fire_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_firing |=> dn_valid);

  assert_move_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_moving == (up_valid && up_ready));

  assert_cancel_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_canceling |-> (st_moving && !st_firing && st_valid));

  assert_dn_cancel_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_cancel && !st_firing) |=> !dn_valid);

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready && !dn_cancel) |=> (dn_valid && $stable(dn_data)));

endmodule

bind stage_ctrl stage_ctrl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .up_valid      (up_valid),
  .up_ready      (up_ready),
  .stage_halt    (stage_halt),
  .stage_throw   (stage_throw),
  .throw_consume (throw_consume),
  .st_valid      (st_valid),
  .st_firing     (st_firing),
  .st_moving     (st_moving),
  .st_canceling  (st_canceling),
  .dn_valid      (dn_valid),
  .dn_ready      (dn_ready),
  .dn_cancel     (dn_cancel),
  .dn_data       (dn_data)
);

// File: tb/stage_ctrl_bench.sv
module stage_ctrl_bench;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic up_valid, up_ready, stage_halt, stage_throw, throw_consume;
  logic st_valid, st_firing, st_moving, st_canceling;
  logic dn_valid, dn_ready, dn_cancel;
  logic [DATA_W-1:0] up_data, dn_data;

  always #4 clk = ~clk;

  stage_ctrl #(.DATA_W(DATA_W)) u_stage_ctrl (.*);

  int checks = 0, errors = 0;
  int seq_next = 0;
  int n_fired = 0, n_out = 0, n_dnc = 0, n_thr = 0;
  int exp_q[$];
  bit thrown[int];
  bit m_qv = 0;
  int m_qd = 0;
  bit hold = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pick(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic step(input int pv, input int ph, input int pt,
                      input int pr, input int pc, input bit cons);
    bit lr, ncan, nrdy, e_fire, e_move, e_canc, e_upr;
    @(negedge clk);
    if (!hold) begin
      up_valid = pick(pv);
      up_data  = DATA_W'(seq_next);
      if (up_valid) seq_next++;
    end
    stage_halt    = pick(ph);
    stage_throw   = pick(pt);
    dn_ready      = pick(pr);
    dn_cancel     = pick(pc);
    throw_consume = cons;
    #1;
    lr     = !m_qv || dn_ready || dn_cancel;
    ncan   = stage_throw && (cons || lr);
    nrdy   = lr && !stage_halt;
    e_upr  = nrdy || ncan;
    e_fire = up_valid && nrdy && !ncan;
    e_move = up_valid && (nrdy || ncan);
    e_canc = up_valid && ncan;
    // R2 R3 R5: upstream ready from link state, halt and throw mode
    chk("R2/R3/R5 up_ready", up_ready, e_upr);
    chk("R6 st_valid", st_valid, up_valid);
    chk("R6 st_firing", st_firing, e_fire);
    chk("R7 st_moving", st_moving, e_move);
    chk("R8 st_canceling", st_canceling, e_canc);
    chk("R1 dn_valid", dn_valid, m_qv);
    if (m_qv) chk("R6 dn_data", int'(dn_data), m_qd);
    // downstream side of the scoreboard
    if (m_qv && dn_cancel) begin
      void'(exp_q.pop_front());
      n_dnc++;
    end else if (m_qv && dn_ready) begin
      n_out++;
      chk("R4 thrown item leaked", int'(thrown.exists(int'(dn_data))), 0);
      if (exp_q.size() == 0) chk("R10 unexpected output", int'(dn_data), -1);
      else chk("R10 order", int'(dn_data), exp_q.pop_front());
    end
    if (e_canc) begin thrown[int'(up_data)] = 1'b1; n_thr++; end
    if (e_fire) begin exp_q.push_back(int'(up_data)); n_fired++; end
    if (lr) begin
      m_qv = e_fire;
      if (e_fire) m_qd = int'(up_data);
    end
    hold = up_valid && !e_move;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_valid = 0; up_data = '0; stage_halt = 0; stage_throw = 0;
    throw_consume = 0; dn_ready = 0; dn_cancel = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset dn_valid", dn_valid, 0);
    chk("R2 reset up_ready", up_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: fill register with downstream stalled, then stall upstream
    repeat (3) step(100, 0, 0, 0, 0, 0);
    // R3: halt with room downstream
    repeat (2) step(100, 100, 0, 100, 0, 0);
    // R4: halt and throw together, throw wins
    repeat (2) step(100, 100, 100, 100, 0, 0);
    // R5: full register, non-consuming throw stalls
    repeat (2) step(100, 0, 0, 0, 0, 0);
    repeat (2) step(100, 0, 100, 0, 0, 0);
    // R5: consuming throw drains upstream while stalled
    repeat (3) step(100, 0, 100, 0, 0, 1);
    // R9: downstream cancel of held item
    repeat (2) step(100, 0, 0, 0, 100, 0);
    // back-to-back throughput
    repeat (20) step(100, 0, 0, 100, 0, 0);
    // random phases in both throw modes (R10, R11)
    repeat (3000) step(70, 20, 15, 60, 10, 0);
    repeat (3000) step(70, 20, 15, 60, 10, 1);
    repeat (2000) step(90, 5, 5, 30, 5, 0);
    repeat (2000) step(90, 5, 30, 80, 20, 1);
    chk("R10 conservation", n_fired, n_out + n_dnc + exp_q.size());
    chk("R4 throws seen", int'(n_thr > 0), 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule